// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Global History and Return Stack

This block sits beside the instruction fetch unit. Every cycle it looks at the fetch address and answers two questions: whether the instruction at that address redirects fetch, and where fetch goes next. It uses three tables.

- A two-way set-associative target buffer records where branches sit, which kind they are, and where they last went.
- A table of 2-bit counters guesses the direction of conditional branches. It is indexed by the fetch address mixed with a register of recent branch outcomes.
- A small stack supplies return addresses.

All three answers are combinational from the fetch address.

Branches are settled later, in order, by one resolution stage. That stage reports each branch's address, kind, actual direction, actual target, and whether the earlier guess was wrong. Resolution trains the counters and the target buffer, and it advances a committed copy of the outcome history and of the return stack.

Fetch-time guesses advance a separate speculative copy. When a wrong guess is reported, both speculative copies are overwritten in one cycle from the committed copies, which by then include that branch's real outcome.

Top module: `bpred_core`

## Requirements
- R1: After reset the target buffer holds no valid entry. Every counter is 2'b01, both outcome histories are zero, and both return stacks have pointer 0 with all entries zero. Any fetch address then predicts not-taken with target fetch_pc+4.
- R2: A fetch address that misses the target buffer predicts not-taken, with target fetch_pc+4.
- R3: A resolved taken branch fills the buffer if it missed, or rewrites the entry if it hit. The entry stores the target and the kind, encoded as 0 conditional, 1 jump, 2 call, 3 return. A later fetch of a jump or call hit predicts taken to the stored target.
- R4: Direction counters are 2-bit and saturating, and start at weakly not-taken (01). A conditional hit predicts taken exactly when its counter's upper bit is set, and then targets the stored address.
- R5: The counter index is the 12-bit history XOR fetch_pc[13:2]. A history update shifts left and inserts the outcome (1 = taken) at bit 0. The committed history and the trained counter track resolved conditional branches that hit the buffer or were taken. The speculative history tracks fetched conditional hits, using the predicted direction.
- R6: The set is pc[9:2] and the tag is pc[31:10]. A fill goes to the way named by the set's single LRU bit. Each resolution that hits or fills a way marks the other way as the next victim.
- R7: A fetched call hit pushes fetch_pc+4 onto the speculative stack. A return hit predicts taken to the stack top and pops it, so nested calls return last-in first-out.
- R8: The stack has 8 entries and its pointer wraps. A ninth push without a pop overwrites the oldest entry.
- R9: On a reported misprediction, the speculative history and stack are replaced by the committed ones. The committed copies already include the resolving branch's outcome, and the replacement is visible on the next cycle.
- R10: When a fetch and a reported misprediction occur in the same cycle, the fetch's speculative update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch address is consumed this cycle (enables speculative updates) |
| fetch_pc | input | 32 | Fetch address |
| pred_taken | output | 1 | Predicted redirect |
| pred_target | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A branch is resolved this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_kind | input | 2 | Kind: 0 conditional, 1 jump, 2 call, 3 return |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual target |
| res_mispredict | input | 1 | The earlier prediction for this branch was wrong |

## Verification
Jumps are placed in one buffer set, and one of them is re-touched before a third is filled. This separates true LRU victim choice from fill order. Nested call and return pairs, interleaved with peeks of the stack top, separate last-in first-out order from queue order. A run of nine pushes separates a wrapping pointer from a saturating one.

A long run of taken outcomes on one conditional branch shows the counter index moving with history, which separates history hashing from plain address indexing. A misprediction is also reported in the same cycle as a call fetch, to show that restore takes priority over the speculative update.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
    // Branch kind as stored in the target buffer and reported by resolution.
    typedef enum logic [1:0] {
        BR_COND = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_RET  = 2'd3
    } br_kind_e;
endpackage

// File: rtl/bpred_btb.sv
module bpred_btb
    import bpred_pkg::*;
#(
    parameter int SETS = 256,
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:2] lk_pc,
    output logic            lk_hit,
    output br_kind_e        lk_kind,
    output logic [PC_W-1:0] lk_target,
    input  logic [PC_W-1:2] up_pc,
    output logic            up_hit,
    input  logic            up_touch,
    input  logic            up_fill,
    input  br_kind_e        up_kind,
    input  logic [PC_W-1:0] up_target
);
    localparam int WAYS  = 2;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = PC_W - 2 - SET_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        br_kind_e         kind;
        logic [PC_W-1:0]  target;
    } ent_t;

    typedef struct packed {
        logic touch;
        logic fill;
        logic way;
        ent_t ent;
    } upd_t;

    logic [SET_W-1:0] lk_set, up_set;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic [WAYS-1:0]  lk_hit_w, up_hit_w;
    ent_t             lk_ent_w [WAYS];
    logic [SETS-1:0]  lru_q;
    upd_t             upd_d;

    assign lk_set = lk_pc[SET_W+1:2];
    assign lk_tag = lk_pc[PC_W-1:SET_W+2];
    assign up_set = up_pc[SET_W+1:2];
    assign up_tag = up_pc[PC_W-1:SET_W+2];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ent_t mem_q [SETS];
        ent_t up_ent;

        assign lk_ent_w[w]  = mem_q[lk_set];
        assign up_ent       = mem_q[up_set];
        assign lk_hit_w[w]  = lk_ent_w[w].valid && (lk_ent_w[w].tag == lk_tag);
        assign up_hit_w[w]  = up_ent.valid && (up_ent.tag == up_tag);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
            end else if (upd_d.fill && (int'(upd_d.way) == w)) begin
                mem_q[up_set] <= upd_d.ent;
            end
        end
    end

    always_comb begin
        lk_hit    = |lk_hit_w;
        lk_kind   = lk_ent_w[lk_hit_w[1]].kind;
        lk_target = lk_ent_w[lk_hit_w[1]].target;
        up_hit    = |up_hit_w;

        upd_d        = '0;
        upd_d.fill   = up_fill;
        upd_d.touch  = up_fill || (up_touch && up_hit);
        upd_d.way    = up_hit ? up_hit_w[1] : lru_q[up_set];
        upd_d.ent    = '{valid: 1'b1, tag: up_tag, kind: up_kind, target: up_target};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (upd_d.touch) begin
            lru_q[up_set] <= ~upd_d.way;
        end
    end
endmodule

// File: rtl/bpred_pht.sv
module bpred_pht #(
    parameter int ENTRIES = 4096
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(ENTRIES)-1:0] rd_idx,
    output logic                       rd_taken,
    input  logic                       up_en,
    input  logic [$clog2(ENTRIES)-1:0] up_idx,
    input  logic                       up_taken
);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [1:0]       ctr;
    } upd_t;

    logic [1:0] ctr_q [ENTRIES];
    logic [1:0] cur;
    upd_t       upd_d;

    assign rd_taken = ctr_q[rd_idx][1];

    always_comb begin
        cur       = ctr_q[up_idx];
        upd_d.en  = up_en;
        upd_d.idx = up_idx;
        if (up_taken) upd_d.ctr = (cur == 2'b11) ? cur : cur + 2'b01;
        else          upd_d.ctr = (cur == 2'b00) ? cur : cur - 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= 2'b01;
        end else if (upd_d.en) begin
            ctr_q[upd_d.idx] <= upd_d.ctr;
        end
    end
endmodule

// File: rtl/bpred_core.sv
module bpred_core
    import bpred_pkg::*;
#(
    parameter int BTB_ENTRIES = 512,
    parameter int PHT_ENTRIES = 4096,
    parameter int RAS_DEPTH   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    output logic        pred_taken,
    output logic [31:0] pred_target,
    input  logic        res_valid,
    input  logic [31:0] res_pc,
    input  logic [1:0]  res_kind,
    input  logic        res_taken,
    input  logic [31:0] res_target,
    input  logic        res_mispredict
);
    localparam int BTB_SETS = BTB_ENTRIES / 2;
    localparam int HIST_W   = $clog2(PHT_ENTRIES);
    localparam int PTR_W    = $clog2(RAS_DEPTH);

    typedef struct packed {
        logic [RAS_DEPTH-1:0][31:0] ent;
        logic [PTR_W-1:0]           ptr;
    } ras_t;

    typedef struct packed {
        logic [HIST_W-1:0] hist_spec;
        logic [HIST_W-1:0] hist_cmt;
        ras_t              ras_spec;
        ras_t              ras_cmt;
    } state_t;

    function automatic ras_t ras_push(ras_t r, logic [31:0] v);
        ras_t o;
        o        = r;
        o.ptr    = r.ptr + PTR_W'(1);
        o.ent[o.ptr] = v;
        return o;
    endfunction

    function automatic ras_t ras_pop(ras_t r);
        ras_t o;
        o     = r;
        o.ptr = r.ptr - PTR_W'(1);
        return o;
    endfunction

    state_t            s_q, s_d;
    logic              f_hit, r_hit, f_dir;
    br_kind_e          f_kind, r_kind;
    logic [31:0]       f_tgt;
    logic [HIST_W-1:0] f_idx, r_idx;
    logic              r_cond_trk, restore;

    assign r_kind     = br_kind_e'(res_kind);
    assign f_idx      = s_q.hist_spec ^ fetch_pc[HIST_W+1:2];
    assign r_idx      = s_q.hist_cmt ^ res_pc[HIST_W+1:2];
    assign r_cond_trk = res_valid && (r_kind == BR_COND) && (r_hit || res_taken);
    assign restore    = res_valid && res_mispredict;

    bpred_btb #(.SETS(BTB_SETS), .PC_W(32)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc[31:2]),
        .lk_hit    (f_hit),
        .lk_kind   (f_kind),
        .lk_target (f_tgt),
        .up_pc     (res_pc[31:2]),
        .up_hit    (r_hit),
        .up_touch  (res_valid),
        .up_fill   (res_valid && res_taken),
        .up_kind   (r_kind),
        .up_target (res_target)
    );

    bpred_pht #(.ENTRIES(PHT_ENTRIES)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_taken (f_dir),
        .up_en    (r_cond_trk),
        .up_idx   (r_idx),
        .up_taken (res_taken)
    );

    // Prediction path
    always_comb begin
        pred_taken  = 1'b0;
        pred_target = fetch_pc + 32'd4;
        if (f_hit) begin
            unique case (f_kind)
                BR_COND: begin
                    if (f_dir) begin
                        pred_taken  = 1'b1;
                        pred_target = f_tgt;
                    end
                end
                BR_RET: begin
                    pred_taken  = 1'b1;
                    pred_target = s_q.ras_spec.ent[s_q.ras_spec.ptr];
                end
                default: begin
                    pred_taken  = 1'b1;
                    pred_target = f_tgt;
                end
            endcase
        end
    end

    // Next-state path
    always_comb begin
        s_d = s_q;
        if (fetch_valid && f_hit) begin
            unique case (f_kind)
                BR_COND: s_d.hist_spec = {s_q.hist_spec[HIST_W-2:0], f_dir};
                BR_CALL: s_d.ras_spec  = ras_push(s_q.ras_spec, fetch_pc + 32'd4);
                BR_RET:  s_d.ras_spec  = ras_pop(s_q.ras_spec);
                default: ;
            endcase
        end
        if (r_cond_trk) s_d.hist_cmt = {s_q.hist_cmt[HIST_W-2:0], res_taken};
        if (res_valid && (r_kind == BR_CALL)) s_d.ras_cmt = ras_push(s_q.ras_cmt, res_pc + 32'd4);
        if (res_valid && (r_kind == BR_RET))  s_d.ras_cmt = ras_pop(s_q.ras_cmt);
        if (restore) begin
            s_d.hist_spec = s_d.hist_cmt;
            s_d.ras_spec  = s_d.ras_cmt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bpred_core_chk.sv
module bpred_core_chk #(
    parameter int HIST_W = 12,
    parameter int PTR_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic [31:0]       fetch_pc,
    input logic              pred_taken,
    input logic [31:0]       pred_target,
    input logic              res_valid,
    input logic              res_mispredict,
    input logic              f_hit,
    input logic [1:0]        f_kind,
    input logic [HIST_W-1:0] hist_spec,
    input logic [HIST_W-1:0] hist_cmt,
    input logic [PTR_W-1:0]  ptr_spec,
    input logic [PTR_W-1:0]  ptr_cmt
);
    a_r2_miss_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !f_hit |-> (!pred_taken && (pred_target == fetch_pc + 32'd4)));

    a_r3_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (f_hit && (f_kind != 2'd0)) |-> pred_taken);

    a_r9_hist_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=> (hist_spec == hist_cmt));

    a_r9_stack_restored: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_mispredict) |=> (ptr_spec == ptr_cmt));

    a_r7_call_pushes: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && f_hit && (f_kind == 2'd2) && !(res_valid && res_mispredict))
        |=> (ptr_spec == PTR_W'($past(ptr_spec) + PTR_W'(1))));

    a_r5_cmt_hist_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(hist_cmt));
endmodule

bind bpred_core bpred_core_chk #(.HIST_W(HIST_W), .PTR_W(PTR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_pc       (fetch_pc),
    .pred_taken     (pred_taken),
    .pred_target    (pred_target),
    .res_valid      (res_valid),
    .res_mispredict (res_mispredict),
    .f_hit          (f_hit),
    .f_kind         (f_kind),
    .hist_spec      (s_q.hist_spec),
    .hist_cmt       (s_q.hist_cmt),
    .ptr_spec       (s_q.ras_spec.ptr),
    .ptr_cmt        (s_q.ras_cmt.ptr)
);

// File: tb/bpred_core_tb_top.sv
module bpred_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken;
    logic [31:0] pred_target;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic [1:0]  res_kind = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_mispredict = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bpred_core dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_target(pred_target), .res_valid(res_valid),
        .res_pc(res_pc), .res_kind(res_kind), .res_taken(res_taken),
        .res_target(res_target), .res_mispredict(res_mispredict)
    );

    // op: 0 peek (no fetch update), 1 fetch, 2 resolve
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] pc;
        logic [1:0]  kind;
        logic        tk;
        logic [15:0] tgt;
        logic        mp;
        logic        et;
        logic [15:0] etgt;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:28] = '{
        '{2'd0, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0044, 4'd2}, // R2 miss
        '{2'd2, 16'h0040, 2'd1, 1'b1, 16'h0500, 1'b1, 1'b0, 16'h0000, 4'd3},
        '{2'd0, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0500, 4'd3}, // R3 fill
        '{2'd2, 16'h0440, 2'd1, 1'b1, 16'h0600, 1'b1, 1'b0, 16'h0000, 4'd6},
        '{2'd0, 16'h0440, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0600, 4'd6}, // R6 way 1
        '{2'd0, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0500, 4'd6}, // R6 way 0
        '{2'd2, 16'h0040, 2'd1, 1'b1, 16'h0500, 1'b0, 1'b0, 16'h0000, 4'd6}, // touch way 0
        '{2'd2, 16'h0840, 2'd1, 1'b1, 16'h0700, 1'b1, 1'b0, 16'h0000, 4'd6}, // evict way 1
        '{2'd0, 16'h0440, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0444, 4'd6}, // R6 evicted
        '{2'd0, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0500, 4'd6},
        '{2'd0, 16'h0840, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0700, 4'd6},
        '{2'd2, 16'h0040, 2'd1, 1'b1, 16'h0580, 1'b1, 1'b0, 16'h0000, 4'd3},
        '{2'd0, 16'h0040, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0580, 4'd3}, // R3 rewrite
        '{2'd2, 16'h0100, 2'd2, 1'b1, 16'h0900, 1'b1, 1'b0, 16'h0000, 4'd7},
        '{2'd2, 16'h0904, 2'd3, 1'b1, 16'h0104, 1'b1, 1'b0, 16'h0000, 4'd7},
        '{2'd1, 16'h0100, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0900, 4'd7}, // R7 call
        '{2'd0, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0104, 4'd7}, // R7 top
        '{2'd1, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0104, 4'd7},
        '{2'd2, 16'h0100, 2'd2, 1'b1, 16'h0900, 1'b0, 1'b0, 16'h0000, 4'd7},
        '{2'd2, 16'h0904, 2'd3, 1'b1, 16'h0104, 1'b0, 1'b0, 16'h0000, 4'd7},
        '{2'd2, 16'h0200, 2'd2, 1'b1, 16'h0A00, 1'b1, 1'b0, 16'h0000, 4'd7},
        '{2'd2, 16'h0904, 2'd3, 1'b1, 16'h0204, 1'b1, 1'b0, 16'h0000, 4'd7},
        '{2'd1, 16'h0100, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0900, 4'd7},
        '{2'd1, 16'h0200, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0A00, 4'd7},
        '{2'd0, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0204, 4'd7}, // R7 inner
        '{2'd1, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0204, 4'd7},
        '{2'd0, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0104, 4'd7}, // R7 outer
        '{2'd2, 16'h0040, 2'd1, 1'b1, 16'h0580, 1'b1, 1'b0, 16'h0000, 4'd9},
        '{2'd0, 16'h0904, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000, 4'd9}  // R9 restored
    };

    task automatic check(input string req, input logic et, input logic [31:0] etgt);
        n_tests++;
        if (pred_taken !== et || pred_target !== etgt) begin
            n_fail++;
            $display("FAIL %s: taken=%0b target=%h expected taken=%0b target=%h",
                     req, pred_taken, pred_target, et, etgt);
        end
    endtask

    task automatic drive(input logic fv, input logic [31:0] fpc, input logic rv,
                         input logic [31:0] rpc, input logic [1:0] kind, input logic tk,
                         input logic [31:0] tgt, input logic mp);
        @(negedge clk);
        fetch_valid = fv; fetch_pc = fpc;
        res_valid = rv; res_pc = rpc; res_kind = kind;
        res_taken = tk; res_target = tgt; res_mispredict = mp;
        #1;
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        fetch_valid = 1'b0; res_valid = 1'b0; res_mispredict = 1'b0;
    endtask

    task automatic peek(input logic [31:0] pc, input logic et, input logic [31:0] etgt,
                        input string req);
        drive(1'b0, pc, 1'b0, '0, 2'd0, 1'b0, '0, 1'b0);
        check(req, et, etgt);
        finish_cycle();
    endtask

    task automatic fetch(input logic [31:0] pc);
        drive(1'b1, pc, 1'b0, '0, 2'd0, 1'b0, '0, 1'b0);
        finish_cycle();
    endtask

    task automatic resolve(input logic [31:0] pc, input logic [1:0] kind, input logic tk,
                           input logic [31:0] tgt, input logic mp);
        drive(1'b0, '0, 1'b1, pc, kind, tk, tgt, mp);
        finish_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty state after reset
        peek(32'h0000_1234, 1'b0, 32'h0000_1238, "R1");

        // Vector walk: R2, R3, R6, R7, R9
        for (int i = 0; i <= 28; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d (vector %0d)", v.req, i);
            drive(v.op == 2'd1, {16'h0, v.pc}, v.op == 2'd2, {16'h0, v.pc}, v.kind, v.tk,
                  {16'h0, v.tgt}, v.mp);
            if (v.op != 2'd2) check(tag, v.et, {16'h0, v.etgt});
            finish_cycle();
        end

        // R10: call fetch in the same cycle as a misprediction; push must be dropped
        drive(1'b1, 32'h0000_0100, 1'b1, 32'h0000_0040, 2'd1, 1'b1, 32'h0000_0580, 1'b1);
        finish_cycle();
        peek(32'h0000_0904, 1'b1, 32'h0000_0000, "R10");

        // R8: nine pushes wrap and overwrite the oldest entry
        fetch(32'h0000_0100);
        for (int k = 0; k < 8; k++) fetch(32'h0000_0200);
        for (int k = 0; k < 8; k++) fetch(32'h0000_0904);
        peek(32'h0000_0904, 1'b1, 32'h0000_0204, "R8");
        resolve(32'h0000_0040, 2'd1, 1'b1, 32'h0000_0580, 1'b1);

        // R5: after one taken outcome the index moves to an untrained counter
        resolve(32'h0000_1000, 2'd0, 1'b1, 32'h0000_2000, 1'b1);
        peek(32'h0000_1000, 1'b0, 32'h0000_1004, "R5");
        for (int k = 0; k < 11; k++) resolve(32'h0000_1000, 2'd0, 1'b1, 32'h0000_2000, 1'b1);
        // R4: history saturated at all ones, fresh counter is weakly not-taken
        peek(32'h0000_1000, 1'b0, 32'h0000_1004, "R4");
        resolve(32'h0000_1000, 2'd0, 1'b1, 32'h0000_2000, 1'b1);
        peek(32'h0000_1000, 1'b1, 32'h0000_2000, "R4");

        // R1: reset clears the buffer again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        peek(32'h0000_0040, 1'b0, 32'h0000_0044, "R1");
        peek(32'h0000_1000, 1'b0, 32'h0000_1004, "R1");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule